// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock

This block sits between a motor-drive controller and the gate drivers of a three-phase bridge. For every phase it receives two ON requests, one for the high-side switch and one for the low-side switch, and produces the two gate enables. It guarantees that the two switches of one phase are never enabled together. It does this by granting the gate to whichever request reached it first.

A request for the opposite arm that comes in while a gate is held is not discarded. While it stays asserted it waits, and it takes the gate on the very clock edge at which the holder's request is seen to drop. If both requests of an idle phase appear in the same cycle, neither arm is granted until one of them goes away. A waiting request that is withdrawn before its turn leaves no trace. The interlock inserts no dead time and signals nothing when it blocks a request, so the request source has to provide any gap between arms. Requests are asynchronous to the clock and pass through a synchroniser before arbitration.

Top module: `il_interlock`

## Requirements
- R1: While `rst` is high, and at the first sample after `rst` is released with all requests low, every gate output is 0.
- R2: For every phase, `gate_upper[p]` and `gate_lower[p]` are never 1 in the same cycle.
- R3: For an idle phase, a request on one arm with the other request low turns on that arm's gate exactly SYNC_STAGES+1 rising edges after the request changes. With the default SYNC_STAGES=2 this is 3 edges. The gate turns off with the same latency after the request drops.
- R4: While the upper gate is on, it stays on for as long as `req_upper` stays high, and the lower gate stays off whatever `req_lower` does.
- R5: While the lower gate is on, it stays on for as long as `req_lower` stays high, and the upper gate stays off whatever `req_upper` does.
- R6: If the holder's request drops while the opposite request is still high, the holder's gate goes off and the opposite gate comes on at the same clock edge. There is no cycle with both gates off and no cycle with both gates on.
- R7: If both requests of a phase with no gate on reach the arbiter in the same cycle, neither gate turns on while both stay high. When one of them drops, the one still high is granted.
- R8: A blocked request that drops before the holder releases is forgotten. After the holder releases, both gates stay off.
- R9: Each phase is arbitrated independently. Requests on one phase never change the gates of another phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_upper | input | NUM_PHASES | High-side ON request per phase (asynchronous) |
| req_lower | input | NUM_PHASES | Low-side ON request per phase (asynchronous) |
| gate_upper | output | NUM_PHASES | High-side gate enable per phase |
| gate_lower | output | NUM_PHASES | Low-side gate enable per phase |

## Verification
The owner register of a phase is the only state the arbiter keeps. A wrong owner therefore shows up at the gate pins one edge after the synchronised requests reach it, which is SYNC_STAGES+1 edges after the pins change. A stale owner shows as a gate that stays on after its request has dropped. A lost transfer shows as a cycle with both gates off while a request is still high. An owner that is copied across phases shows as a gate that moves with another phase's pattern. Sweeping every four-step request sequence on all three phases at once, each phase driven with a different rotation of the sequence, drives each of these faults to the pins within a few cycles.

// File: rtl/il_pkg.sv
package il_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_UPPER = 2'b01,
        OWN_LOWER = 2'b10
    } owner_e;

    typedef struct packed {
        logic upper;
        logic lower;
    } arm_pair_t;

    // Next holder of one phase, given the current holder and the synchronised requests.
    function automatic owner_e next_owner(owner_e cur, arm_pair_t req);
        owner_e nxt;
        case (cur)
            OWN_UPPER: begin
                if (req.upper)      nxt = OWN_UPPER;
                else if (req.lower) nxt = OWN_LOWER;
                else                nxt = OWN_NONE;
            end
            OWN_LOWER: begin
                if (req.lower)      nxt = OWN_LOWER;
                else if (req.upper) nxt = OWN_UPPER;
                else                nxt = OWN_NONE;
            end
            default: begin
                // Idle: a lone request wins; a tie grants nobody.
                if (req.upper && !req.lower)      nxt = OWN_UPPER;
                else if (req.lower && !req.upper) nxt = OWN_LOWER;
                else                              nxt = OWN_NONE;
            end
        endcase
        return nxt;
    endfunction

    function automatic arm_pair_t gates_of(owner_e own);
        arm_pair_t g;
        g.upper = (own == OWN_UPPER);
        g.lower = (own == OWN_LOWER);
        return g;
    endfunction

endpackage

// File: rtl/il_sync.sv
module il_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[LAST];

endmodule

// File: rtl/il_phase_arb.sv
module il_phase_arb
    import il_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  arm_pair_t req,
    output arm_pair_t gate
);
    owner_e owner_q;

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_NONE;
        else     owner_q <= next_owner(owner_q, req);
    end

    assign gate = gates_of(owner_q);

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gate.upper && gate.lower)); // R2
    AST_UPPER_DROP: assert property (@(posedge clk) disable iff (rst)
        !req.upper |=> !gate.upper); // R3
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        gate.upper && req.upper |=> gate.upper && !gate.lower); // R4
    AST_LOWER_HOLD: assert property (@(posedge clk) disable iff (rst)
        gate.lower && req.lower |=> gate.lower && !gate.upper); // R5
    AST_HANDOVER_UP: assert property (@(posedge clk) disable iff (rst)
        gate.upper && !req.upper && req.lower |=> gate.lower); // R6
    AST_HANDOVER_LO: assert property (@(posedge clk) disable iff (rst)
        gate.lower && !req.lower && req.upper |=> gate.upper); // R6
    AST_TIE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !gate.upper && !gate.lower && req.upper && req.lower
        |=> !gate.upper && !gate.lower); // R7

endmodule

// File: rtl/il_interlock.sv
module il_interlock
    import il_pkg::*;
#(
    parameter int NUM_PHASES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] req_upper,
    input  logic [NUM_PHASES-1:0] req_lower,
    output logic [NUM_PHASES-1:0] gate_upper,
    output logic [NUM_PHASES-1:0] gate_lower
);
    localparam int REQ_W = 2 * NUM_PHASES;

    logic [REQ_W-1:0] raw_req;
    logic [REQ_W-1:0] sync_req;

    assign raw_req = {req_upper, req_lower};

    il_sync #(
        .WIDTH  (REQ_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_req),
        .q   (sync_req)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        arm_pair_t ph_req;
        arm_pair_t ph_gate;

        assign ph_req.upper = sync_req[NUM_PHASES + p];
        assign ph_req.lower = sync_req[p];

        il_phase_arb u_arb (
            .clk  (clk),
            .rst  (rst),
            .req  (ph_req),
            .gate (ph_gate)
        );

        assign gate_upper[p] = ph_gate.upper;
        assign gate_lower[p] = ph_gate.lower;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (gate_upper == '0) && (gate_lower == '0)); // R1

endmodule

// File: tb/il_interlock_tb.sv
`timescale 1ns/1ps
module il_interlock_tb;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] req_u = '0;
    logic [NP-1:0] req_l = '0;
    logic [NP-1:0] g_u;
    logic [NP-1:0] g_l;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    il_interlock #(.NUM_PHASES(NP), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_upper  (req_u),
        .req_lower  (req_l),
        .gate_upper (g_u),
        .gate_lower (g_l)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare phase p's gates against the expected pair {upper,lower}.
    task automatic check_pair(input int p, input int exp, input string req);
        int act;
        act = {30'd0, g_u[p], g_l[p]};
        check(act == exp, req, act, exp);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_u = '0;
        req_l = '0;
        edges(3);
        rst = 1'b0;
    endtask

    // Holder model from the requirements: 0 none, 1 upper, 2 lower.
    function automatic int model(int own, bit u, bit l);
        if (own == 1) return u ? 1 : (l ? 2 : 0);
        if (own == 2) return l ? 2 : (u ? 1 : 0);
        if (u && !l) return 1;
        if (l && !u) return 2;
        return 0;
    endfunction

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int own [NP];
        // R1: reset state
        edges(2);
        for (int p = 0; p < NP; p++) check_pair(p, 0, "R1 in reset");
        rst = 1'b0;
        edges(1);
        for (int p = 0; p < NP; p++) check_pair(p, 0, "R1 after release");

        // R3: latency of a lone upper request, on and off
        req_u[0] = 1'b1;
        edges(2);
        check_pair(0, 0, "R3 upper not yet on");
        edges(1);
        check_pair(0, 2, "R3 upper on at edge 3");
        req_u[0] = 1'b0;
        edges(2);
        check_pair(0, 2, "R3 upper still on");
        edges(1);
        check_pair(0, 0, "R3 upper off at edge 3");

        // R4 and R6: upper holds against lower, then hands over on the same edge
        req_u[1] = 1'b1;
        edges(4);
        req_l[1] = 1'b1;
        edges(5);
        check_pair(1, 2, "R4 lower blocked while upper held");
        req_u[1] = 1'b0;
        edges(2);
        check_pair(1, 2, "R6 before handover");
        edges(1);
        check_pair(1, 1, "R6 handover edge");
        req_l[1] = 1'b0;
        edges(4);
        check_pair(1, 0, "R6 released");

        // R5 and R8: lower holds, blocked upper withdrawn is forgotten
        req_l[2] = 1'b1;
        edges(4);
        req_u[2] = 1'b1;
        edges(5);
        check_pair(2, 1, "R5 upper blocked while lower held");
        req_u[2] = 1'b0;
        edges(4);
        req_l[2] = 1'b0;
        edges(2);
        check_pair(2, 1, "R8 lower still held");
        edges(1);
        check_pair(2, 0, "R8 forgotten request not granted");
        edges(4);
        check_pair(2, 0, "R8 stays idle");

        // R7: simultaneous rise, then lower drops
        req_u[0] = 1'b1;
        req_l[0] = 1'b1;
        edges(6);
        check_pair(0, 0, "R7 tie grants nobody");
        req_l[0] = 1'b0;
        edges(2);
        check_pair(0, 0, "R7 before resolve");
        edges(1);
        check_pair(0, 2, "R7 remaining request granted");
        req_u[0] = 1'b0;
        edges(4);

        // R9 and R2: every 4-step sequence, each phase on its own rotation
        for (int s = 0; s < 256; s++) begin
            do_reset();
            for (int p = 0; p < NP; p++) own[p] = 0;
            for (int step = 0; step < 4; step++) begin
                for (int p = 0; p < NP; p++) begin
                    int code;
                    code = (s >> (2 * ((step + p) % 4))) & 3;
                    req_u[p] = code[1];
                    req_l[p] = code[0];
                    own[p] = model(own[p], code[1], code[0]);
                end
                edges(4);
                for (int p = 0; p < NP; p++) begin
                    int exp;
                    exp = (own[p] == 1) ? 2 : ((own[p] == 2) ? 1 : 0);
                    check_pair(p, exp, "R9 sweep holder");
                    check(!(g_u[p] && g_l[p]), "R2 exclusive", {30'd0, g_u[p], g_l[p]}, exp);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule